// File: doc/BRIEF.md
# Interrupt Request Priority Arbiter

This block keeps the interrupt state of a single processor for 256 vectors: which vectors are waiting to be taken, which are being serviced, and whether each recorded request was level or edge triggered. From that state it picks the vector that may be handed to the core now. It also derives the processor priority from the task priority and the highest class being serviced. When an end-of-interrupt retires a level-triggered vector, it announces that vector so that the interrupt source can re-arm.

The core drives requests in one at a time as a vector with a level flag. It writes the task priority through its own port. It strobes accept with the vector it took, and strobes end-of-interrupt when the handler finishes. A request below vector 16 is reported as an illegal-vector error and is not kept. All requests are dropped while the software-enable input is low.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset the pending, in-service and trigger-mode bits and the task priority are all zero, so `deliv_valid` is 0, `ppr` is 0x00, and neither pulse output is high.
- R2: A request with `sw_enable` high and a vector below 16 is not recorded. Instead `err_illegal` is high for exactly one cycle, one rising edge after the request cycle.
- R3: While `sw_enable` is low, a request of any vector is dropped. It leaves no pending bit and raises no error.
- R4: The candidate is the highest pending vector in 32..255. Vectors 16..31 may be recorded but are never offered. `deliv_vector` and `deliv_valid` reflect an input on the second rising edge after the input cycle.
- R5: `deliv_valid` is 1 only when the candidate class (vector[7:4]) is strictly greater than `ppr[7:4]`.
- R6: The processor priority equals the task priority when TPR[7:4] is at least the class of the highest in-service vector (taken as 0 when nothing is in service). Otherwise it equals that vector with bits [3:0] cleared. `ppr` updates on the second rising edge after the input cycle.
- R7: Accept of a pending vector clears its pending bit, sets its in-service bit and recomputes the priority. Accept of a vector that is not pending changes nothing.
- R8: End-of-interrupt clears the highest in-service bit among vectors 32..255 and recomputes the priority. With no such bit set it has no effect.
- R9: A recorded request sets the trigger-mode bit when `req_level` is 1 and clears it when it is 0. On end-of-interrupt, if the retired vector's trigger-mode bit is set, `eoi_bcast_valid` pulses for one cycle with `eoi_bcast_vector`, one rising edge after the strobe.
- R10: A task-priority write stores the 8-bit value and the processor priority is recomputed from it without any other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_enable | input | 1 | Software enable; requests are dropped while low |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data |
| accept | input | 1 | Core accepted a vector |
| accept_vector | input | 8 | Vector the core accepted |
| eoi | input | 1 | End-of-interrupt strobe |
| deliv_valid | output | 1 | A deliverable vector is offered |
| deliv_vector | output | 8 | Highest deliverable candidate vector |
| ppr | output | 8 | Processor priority |
| eoi_bcast_valid | output | 1 | Level-triggered vector retired |
| eoi_bcast_vector | output | 8 | Retired level-triggered vector |
| err_illegal | output | 1 | Illegal receive vector pulse |

## Verification
The checker enforces on every cycle that an error pulse only follows an enabled request below 16 and that no pulse follows a disabled request. It also enforces that an offered vector lies in 32..255 and sits strictly above the processor-priority class, and that a broadcast only follows an end-of-interrupt strobe. The ordering rules are left to the bench scenarios. These are the choice of highest pending and highest in-service vector, the priority that results from nested accepts and task-priority writes, ignored accepts and empty end-of-interrupts, and the way a later edge request clears a level trigger bit so that no broadcast follows.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int VEC_W      = 8;
  localparam int NUM_VEC    = 1 << VEC_W;
  localparam int GRP_W      = 32;
  localparam int RSVD_LO    = 32;
  localparam int ILLEGAL_LO = 16;
  localparam int CLASS_W    = 4;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W = 256,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  bits_in,
  output logic [IW-1:0] top_idx,
  output logic          found
);
  always_comb begin
    top_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (bits_in[i]) begin
        top_idx = IW'(i);
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state #(
  parameter int NUM_VEC = 256,
  parameter int GRP_W   = 32,
  localparam int VW     = $clog2(NUM_VEC),
  localparam int NGRP   = NUM_VEC / GRP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [VW-1:0]      set_vec,
  input  logic               set_lvl,
  input  logic               acc_en,
  input  logic [VW-1:0]      acc_vec,
  input  logic               ret_en,
  input  logic [VW-1:0]      ret_vec,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] serv,
  output logic [NUM_VEC-1:0] trig
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[g*GRP_W +: GRP_W] <= '0;
        serv[g*GRP_W +: GRP_W] <= '0;
        trig[g*GRP_W +: GRP_W] <= '0;
      end else begin
        for (int b = 0; b < GRP_W; b++) begin
          if (set_en && set_vec == VW'(g*GRP_W + b)) begin
            pend[g*GRP_W + b] <= 1'b1;
            trig[g*GRP_W + b] <= set_lvl;
          end else if (acc_en && acc_vec == VW'(g*GRP_W + b)) begin
            pend[g*GRP_W + b] <= 1'b0;
          end
          if (acc_en && acc_vec == VW'(g*GRP_W + b))
            serv[g*GRP_W + b] <= 1'b1;
          else if (ret_en && ret_vec == VW'(g*GRP_W + b))
            serv[g*GRP_W + b] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NV = NUM_VEC,
  parameter int GW = GRP_W,
  parameter int LO = RSVD_LO,
  parameter int IL = ILLEGAL_LO,
  localparam int VW = $clog2(NV)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_enable,
  input  logic          req_valid,
  input  logic [VW-1:0] req_vector,
  input  logic          req_level,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          accept,
  input  logic [VW-1:0] accept_vector,
  input  logic          eoi,
  output logic          deliv_valid,
  output logic [VW-1:0] deliv_vector,
  output logic [VW-1:0] ppr,
  output logic          eoi_bcast_valid,
  output logic [VW-1:0] eoi_bcast_vector,
  output logic          err_illegal
);
  localparam int CW = VW - 4;
  localparam logic [NV-1:0] HI_MASK = {{(NV-LO){1'b1}}, {LO{1'b0}}};

  logic [NV-1:0] pend, serv, trig;
  logic [VW-1:0] tpr_q;
  logic [VW-1:0] cand_vec, serv_top, ret_vec;
  logic          cand_found, serv_found, ret_found;
  logic          req_ok, req_low, acc_ok, ret_ok;
  logic [VW-1:0] serv_eff, ppr_c;

  assign req_low = req_valid && sw_enable && (req_vector < VW'(IL));
  assign req_ok  = req_valid && sw_enable && !(req_vector < VW'(IL));
  assign acc_ok  = accept && pend[accept_vector];
  assign ret_ok  = eoi && ret_found;

  irq_vec_state #(.NUM_VEC(NV), .GRP_W(GW)) u_state (
    .clk(clk), .rst(rst),
    .set_en(req_ok), .set_vec(req_vector), .set_lvl(req_level),
    .acc_en(acc_ok), .acc_vec(accept_vector),
    .ret_en(ret_ok), .ret_vec(ret_vec),
    .pend(pend), .serv(serv), .trig(trig)
  );

  irq_prio_enc #(.W(NV)) u_cand (
    .bits_in(pend & HI_MASK), .top_idx(cand_vec), .found(cand_found));
  irq_prio_enc #(.W(NV)) u_serv (
    .bits_in(serv), .top_idx(serv_top), .found(serv_found));
  irq_prio_enc #(.W(NV)) u_ret (
    .bits_in(serv & HI_MASK), .top_idx(ret_vec), .found(ret_found));

  always_comb begin
    serv_eff = serv_found ? serv_top : '0;
    if (tpr_q[VW-1 -: CW] >= serv_eff[VW-1 -: CW])
      ppr_c = tpr_q;
    else
      ppr_c = {serv_eff[VW-1 -: CW], 4'h0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tpr_q            <= '0;
      deliv_valid      <= 1'b0;
      deliv_vector     <= '0;
      ppr              <= '0;
      eoi_bcast_valid  <= 1'b0;
      eoi_bcast_vector <= '0;
      err_illegal      <= 1'b0;
    end else begin
      if (tpr_we) tpr_q <= tpr_wdata;
      ppr              <= ppr_c;
      deliv_vector     <= cand_vec;
      deliv_valid      <= cand_found && (cand_vec[VW-1 -: CW] > ppr_c[VW-1 -: CW]);
      err_illegal      <= req_low;
      eoi_bcast_valid  <= ret_ok && trig[ret_vec];
      eoi_bcast_vector <= ret_vec;
    end
  end
endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk (
  input logic       clk,
  input logic       rst,
  input logic       sw_enable,
  input logic       req_valid,
  input logic [7:0] req_vector,
  input logic       eoi,
  input logic       deliv_valid,
  input logic [7:0] deliv_vector,
  input logic [7:0] ppr,
  input logic       eoi_bcast_valid,
  input logic       err_illegal
);
  p_err_low_vec_r2: assert property (@(posedge clk) disable iff (rst)
    err_illegal |-> $past(req_valid && sw_enable && req_vector < 8'd16));

  p_no_err_disabled_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!sw_enable) |-> !err_illegal);

  p_deliv_range_r4: assert property (@(posedge clk) disable iff (rst)
    deliv_valid |-> deliv_vector >= 8'd32);

  p_deliv_above_ppr_r5: assert property (@(posedge clk) disable iff (rst)
    deliv_valid |-> deliv_vector[7:4] > ppr[7:4]);

  p_bcast_after_eoi_r9: assert property (@(posedge clk) disable iff (rst)
    eoi_bcast_valid |-> $past(eoi));
endmodule

bind irq_prio_arb irq_prio_arb_chk u_chk (
  .clk(clk), .rst(rst), .sw_enable(sw_enable), .req_valid(req_valid),
  .req_vector(req_vector), .eoi(eoi), .deliv_valid(deliv_valid),
  .deliv_vector(deliv_vector), .ppr(ppr),
  .eoi_bcast_valid(eoi_bcast_valid), .err_illegal(err_illegal)
);

// File: tb/irq_prio_arb_test.sv
module irq_prio_arb_test;
  logic clk = 0, rst = 1;
  logic sw_enable = 0, req_valid = 0, req_level = 0;
  logic [7:0] req_vector = 0, tpr_wdata = 0, accept_vector = 0;
  logic tpr_we = 0, accept = 0, eoi = 0;
  logic deliv_valid, eoi_bcast_valid, err_illegal;
  logic [7:0] deliv_vector, ppr, eoi_bcast_vector;

  int checks = 0, errors = 0;
  logic [8:0] expq[$];   // {kind, vector}: kind 0 = error pulse, 1 = broadcast
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_arb uut (
    .clk(clk), .rst(rst), .sw_enable(sw_enable), .req_valid(req_valid),
    .req_vector(req_vector), .req_level(req_level), .tpr_we(tpr_we),
    .tpr_wdata(tpr_wdata), .accept(accept), .accept_vector(accept_vector),
    .eoi(eoi), .deliv_valid(deliv_valid), .deliv_vector(deliv_vector),
    .ppr(ppr), .eoi_bcast_valid(eoi_bcast_valid),
    .eoi_bcast_vector(eoi_bcast_vector), .err_illegal(err_illegal));

  // monitor: every pulse must match the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && (err_illegal || eoi_bcast_valid)) begin
      logic [8:0] got;
      got = err_illegal ? {1'b0, 8'h00} : {1'b1, eoi_bcast_vector};
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R2/R9 unexpected pulse actual=%h expected=none", got);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        if (e != got) begin
          errors++;
          $display("FAIL R2/R9 pulse actual=%h expected=%h", got, e);
        end
      end
    end
  end

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_req(input logic [7:0] v, input logic lvl, input bit exp_err);
    if (exp_err) expq.push_back({1'b0, 8'h00});
    @(negedge clk); req_valid = 1; req_vector = v; req_level = lvl;
    @(negedge clk); req_valid = 0;
    settle();
  endtask

  task automatic do_tpr(input logic [7:0] v);
    @(negedge clk); tpr_we = 1; tpr_wdata = v;
    @(negedge clk); tpr_we = 0;
    settle();
  endtask

  task automatic do_acc(input logic [7:0] v);
    @(negedge clk); accept = 1; accept_vector = v;
    @(negedge clk); accept = 0;
    settle();
  endtask

  task automatic do_eoi(input bit exp_b, input logic [7:0] v);
    if (exp_b) expq.push_back({1'b1, v});
    @(negedge clk); eoi = 1;
    @(negedge clk); eoi = 0;
    settle();
  endtask

  task automatic chk(input string tag, input logic ev, input logic [7:0] evec,
                     input logic [7:0] eppr);
    checks++;
    if (deliv_valid !== ev || (ev && deliv_vector !== evec) || ppr !== eppr) begin
      errors++;
      $display("FAIL %s actual valid=%b vec=%h ppr=%h expected valid=%b vec=%h ppr=%h",
               tag, deliv_valid, deliv_vector, ppr, ev, evec, eppr);
    end
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog actual=timeout expected=finish");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk); rst = 0;
    settle();
    chk("R1 reset", 0, 0, 8'h00);
    checks++;
    if (err_illegal !== 0 || eoi_bcast_valid !== 0) begin
      errors++; $display("FAIL R1 pulses actual=%b%b expected=00", err_illegal, eoi_bcast_valid);
    end

    do_req(8'h50, 0, 0);
    do_req(8'h05, 0, 0);
    chk("R3 disabled drop", 0, 0, 8'h00);

    sw_enable = 1;
    do_req(8'h05, 0, 1);
    chk("R2 low vector not recorded", 0, 0, 8'h00);
    do_req(8'h14, 0, 0);
    chk("R4 vector 20 not offered", 0, 0, 8'h00);
    do_req(8'h41, 0, 0);
    do_req(8'h83, 1, 0);
    chk("R4 highest pending", 1, 8'h83, 8'h00);

    do_tpr(8'h85);
    chk("R5 R10 equal class masked", 0, 0, 8'h85);
    do_tpr(8'h70);
    chk("R5 R10 lower tpr", 1, 8'h83, 8'h70);

    do_acc(8'h83);
    chk("R6 R7 accept raises ppr", 0, 0, 8'h80);
    do_acc(8'h99);
    chk("R7 accept not pending ignored", 0, 0, 8'h80);

    do_req(8'hA2, 0, 0);
    chk("R5 higher class offered", 1, 8'hA2, 8'h80);
    do_acc(8'hA2);
    chk("R7 nested accept", 0, 0, 8'hA0);
    do_tpr(8'hB4);
    chk("R6 R10 tpr above service", 0, 0, 8'hB4);
    do_tpr(8'h00);
    chk("R6 service class", 0, 0, 8'hA0);

    do_eoi(0, 8'h00);
    chk("R8 eoi retires A2 edge", 0, 0, 8'h80);
    do_eoi(1, 8'h83);
    chk("R8 R9 eoi retires 83 level", 1, 8'h41, 8'h00);
    do_eoi(0, 8'h00);
    chk("R8 empty eoi", 1, 8'h41, 8'h00);

    do_req(8'h60, 1, 0);
    do_req(8'h60, 0, 0);
    chk("R4 new top", 1, 8'h60, 8'h00);
    do_acc(8'h60);
    chk("R7 accept 60", 0, 0, 8'h60);
    do_eoi(0, 8'h00);
    chk("R9 edge rewrite clears trigger", 1, 8'h41, 8'h00);
    do_acc(8'h41);
    do_eoi(0, 8'h00);
    chk("R4 only vector 20 left", 0, 0, 8'h00);

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R2/R9 missing pulses actual=%0d expected=0", expq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule